// File: doc/BRIEF.md
# Segment Bounds Protection Unit

This unit keeps several applications that share one small embedded processor out of each other's memory. Every application slot owns two windows of local memory, one for code and one for data. Each window is described by a base byte address and a length in bytes. A privileged configuration port fills a per-slot table of these windows. The same port fills a square call-permission matrix that says which slot may call into which other slot.

When trusted dispatch logic hands an incoming message to a slot, the unit copies that slot's two windows into its active registers. From then on every instruction fetch is checked against the active code window, and every load or store against the active data window, in the same cycle as the access. An access that falls outside its window is refused. The unit latches the faulting address, the slot and the access kind, and then refuses all further activity until the exception is cleared.

A slot may call into another slot only when the matrix allows that pair. An allowed call pushes the caller onto a small hardware return stack and switches the active windows to the callee's. A return pops the stack and reloads the caller's windows. Calling with a full stack, returning with an empty one, and calling without permission are all violations.

Top module: `segg_top`

## Requirements
- R1: After reset the active slot is 0, no fault is pending, the return stack is empty, every table window has length 0 and every permission bit is 0, so every access is refused.
- R2: An access of size code s (0, 1, 2, 3 meaning 1, 2, 4, 8 bytes) at address a is granted (acc_ok high in the same cycle) exactly when base <= a and a + bytes <= base + length of the active window. Type code 00 (fetch) is checked against the code window, and 01 (load) and 1x (store) against the data window.
- R3: A window of length 0 refuses every access at every address.
- R4: A refused access raises fault on the next clock. It records fault_kind 0 fetch, 1 load, 2 store, 3 call not permitted, 4 return stack overflow, 5 return with empty stack, with fault_app set to the active slot. fault_addr holds the access address for kinds 0 to 2, the target slot for kinds 3 and 4, and 0 for kind 5.
- R5: While fault is high, acc_ok, call_ok and ret_ok stay low and no call or return changes state. exc_clear drops fault on the next clock.
- R6: A dispatch makes the given slot active on the next clock, loads its windows from the table as they stood before that clock, and empties the return stack. Table writes after a load do not change the active windows until the next load.
- R7: A call to slot t is granted (call_ok) only when bit t of the active slot's permission row is 1. The callee becomes active with its windows on the next clock. A refused call is fault kind 3 and leaves the active slot unchanged.
- R8: The return stack holds 4 callers. A permitted call while 4 are held is fault kind 4 and does not switch.
- R9: A return (ret_ok) pops the most recent caller and reloads its windows on the next clock. A return with an empty stack is fault kind 5.
- R10: A permission write replaces only the addressed row. Bit j of row i allows slot i to call slot j.
- R11: Within one cycle, dispatch overrides call and call overrides return. An access refused in the same cycle cancels a call or return. The access is always checked against the windows active before that cycle's switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Write one window of the per-slot table |
| seg_is_data | input | 1 | 0 selects the code window, 1 the data window |
| seg_app | input | 3 | Slot whose window is written |
| seg_base | input | 15 | Window base byte address |
| seg_len | input | 16 | Window length in bytes |
| perm_we | input | 1 | Write one permission row |
| perm_app | input | 3 | Calling slot whose row is written |
| perm_row | input | 8 | Bit j set allows calls into slot j |
| dispatch_valid | input | 1 | Load a slot's windows for a new message |
| dispatch_app | input | 3 | Slot targeted by the message |
| acc_valid | input | 1 | Access request |
| acc_type | input | 2 | 00 fetch, 01 load, 1x store |
| acc_addr | input | 15 | Access byte address |
| acc_size | input | 2 | Size code, bytes = 1 << code |
| acc_ok | output | 1 | Access granted this cycle |
| call_valid | input | 1 | Cross-slot call request |
| call_app | input | 3 | Callee slot |
| call_ok | output | 1 | Call granted this cycle |
| ret_valid | input | 1 | Return from cross-slot call |
| ret_ok | output | 1 | Return granted this cycle |
| exc_clear | input | 1 | Clear a pending fault |
| cur_app | output | 3 | Active slot |
| fault | output | 1 | Exception pending |
| fault_kind | output | 3 | Kind of the recorded violation |
| fault_addr | output | 15 | Recorded address or target slot |
| fault_app | output | 3 | Slot active at the violation |

## Verification
The bench aims at the window edges. It tries the last legal byte and an access one byte past the end, where an off-by-one limit compare would wrongly grant or refuse. It tries an address just below the base and a zero-length window, where a design that skips the length test would grant the base address itself. It fills the return stack to exactly four callers, then calls once more and returns once too often. A design with a miscounted stack would switch slots or pop garbage instead of faulting. It also drives dispatch, call and return together with a refused access in one cycle, and accesses during a pending fault. A wrong priority shows up there as a switched active slot, or as a grant while the fault is pending.

// File: rtl/segg_pkg.sv
package segg_pkg;
    localparam int ADDR_W    = 15;
    localparam int LEN_W     = 16;
    localparam int N_APPS    = 8;
    localparam int APP_W     = $clog2(N_APPS);
    localparam int STK_DEPTH = 4;
    localparam int SIZE_W    = 2;
    localparam int KIND_W    = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [APP_W-1:0]  app_t;

    typedef struct packed {
        addr_t base;
        len_t  len;
    } seg_t;

    typedef enum logic [KIND_W-1:0] {
        FK_FETCH = 3'd0,
        FK_LOAD  = 3'd1,
        FK_STORE = 3'd2,
        FK_CALL  = 3'd3,
        FK_OVF   = 3'd4,
        FK_UNDER = 3'd5
    } fkind_e;

    localparam logic [1:0] ACC_FETCH = 2'b00;
    localparam logic [1:0] ACC_LOAD  = 2'b01;
endpackage

// File: rtl/segg_bounds.sv
module segg_bounds #(
    parameter int AW = 15,
    parameter int LW = 16,
    parameter int SW = 2
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] addr,
    input  logic [SW-1:0] size_code,
    output logic          in_bounds
);
    localparam int EW = ((AW > LW) ? AW : LW) + 2 + (1 << SW);

    logic [EW-1:0] lo;
    logic [EW-1:0] hi;
    logic [EW-1:0] lim;

    always_comb begin
        lo        = EW'(addr);
        hi        = lo + (EW'(1) << size_code);
        lim       = EW'(base) + EW'(len);
        in_bounds = (len != '0) && (lo >= EW'(base)) && (hi <= lim);
    end

    // R3: an empty window never grants
    always_comb begin
        if (len == '0) begin
            a_r3_empty_denies: assert (!in_bounds);
        end
    end
endmodule

// File: rtl/segg_stack.sv
module segg_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t stk_q, stk_d;

    always_comb begin
        stk_d   = stk_q;
        top_val = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == stk_q.cnt) top_val = stk_q.ent[i];
        end
        if (flush) begin
            stk_d.cnt = '0;
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == stk_q.cnt) stk_d.ent[i] = push_val;
            end
            stk_d.cnt = stk_q.cnt + 1'b1;
        end else if (pop) begin
            stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign full  = (stk_q.cnt == CW'(DEPTH));
    assign empty = (stk_q.cnt == '0);

    // R8: never push onto a full stack, count stays in range
    a_r8_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> !full);
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= CW'(DEPTH));
    // R9: never pop an empty stack
    a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !push) |-> !empty);
endmodule

// File: rtl/segg_top.sv
module segg_top
    import segg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic              seg_is_data,
    input  logic [APP_W-1:0]  seg_app,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              perm_we,
    input  logic [APP_W-1:0]  perm_app,
    input  logic [N_APPS-1:0] perm_row,
    input  logic              dispatch_valid,
    input  logic [APP_W-1:0]  dispatch_app,
    input  logic              acc_valid,
    input  logic [1:0]        acc_type,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              acc_ok,
    input  logic              call_valid,
    input  logic [APP_W-1:0]  call_app,
    output logic              call_ok,
    input  logic              ret_valid,
    output logic              ret_ok,
    input  logic              exc_clear,
    output logic [APP_W-1:0]  cur_app,
    output logic              fault,
    output logic [KIND_W-1:0] fault_kind,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [APP_W-1:0]  fault_app
);
    typedef struct packed {
        seg_t [N_APPS-1:0]              itab;
        seg_t [N_APPS-1:0]              dtab;
        logic [N_APPS-1:0][N_APPS-1:0]  perm;
        seg_t                           iact;
        seg_t                           dact;
        app_t                           cur;
        logic                           flt;
        fkind_e                         kind;
        addr_t                          faddr;
        app_t                           fapp;
    } st_t;

    st_t  st_q, st_d;

    seg_t chk_seg;
    logic in_bounds;
    logic acc_go, acc_viol, cmd_open, call_perm;
    logic call_den, call_ovf, ret_und;
    logic stk_full, stk_empty, stk_push, stk_pop;
    app_t stk_top;

    assign chk_seg = (acc_type == ACC_FETCH) ? st_q.iact : st_q.dact;

    segg_bounds #(.AW(ADDR_W), .LW(LEN_W), .SW(SIZE_W)) u_bounds (
        .base      (chk_seg.base),
        .len       (chk_seg.len),
        .addr      (acc_addr),
        .size_code (acc_size),
        .in_bounds (in_bounds)
    );

    segg_stack #(.DEPTH(STK_DEPTH), .W(APP_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (dispatch_valid),
        .push     (stk_push),
        .pop      (stk_pop),
        .push_val (st_q.cur),
        .top_val  (stk_top),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    always_comb begin
        acc_go    = acc_valid && !st_q.flt;
        acc_viol  = acc_go && !in_bounds;
        acc_ok    = acc_go && in_bounds;
        cmd_open  = !st_q.flt && !acc_viol && !dispatch_valid;
        call_perm = st_q.perm[st_q.cur][call_app];
        call_ok   = call_valid && cmd_open && call_perm && !stk_full;
        call_den  = call_valid && cmd_open && !call_perm;
        call_ovf  = call_valid && cmd_open && call_perm && stk_full;
        ret_ok    = ret_valid && !call_valid && cmd_open && !stk_empty;
        ret_und   = ret_valid && !call_valid && cmd_open && stk_empty;
        stk_push  = call_ok;
        stk_pop   = ret_ok;

        st_d = st_q;

        // active slot switching
        if (dispatch_valid) begin
            st_d.cur  = dispatch_app;
            st_d.iact = st_q.itab[dispatch_app];
            st_d.dact = st_q.dtab[dispatch_app];
        end else if (call_ok) begin
            st_d.cur  = call_app;
            st_d.iact = st_q.itab[call_app];
            st_d.dact = st_q.dtab[call_app];
        end else if (ret_ok) begin
            st_d.cur  = stk_top;
            st_d.iact = st_q.itab[stk_top];
            st_d.dact = st_q.dtab[stk_top];
        end

        // violation capture
        if (acc_viol) begin
            st_d.flt   = 1'b1;
            st_d.faddr = acc_addr;
            st_d.fapp  = st_q.cur;
            if (acc_type == ACC_FETCH)     st_d.kind = FK_FETCH;
            else if (acc_type == ACC_LOAD) st_d.kind = FK_LOAD;
            else                           st_d.kind = FK_STORE;
        end else if (call_den || call_ovf) begin
            st_d.flt   = 1'b1;
            st_d.faddr = ADDR_W'(call_app);
            st_d.fapp  = st_q.cur;
            st_d.kind  = call_den ? FK_CALL : FK_OVF;
        end else if (ret_und) begin
            st_d.flt   = 1'b1;
            st_d.faddr = '0;
            st_d.fapp  = st_q.cur;
            st_d.kind  = FK_UNDER;
        end else if (st_q.flt && exc_clear) begin
            st_d.flt = 1'b0;
        end

        // privileged table writes
        if (seg_we) begin
            if (seg_is_data) begin
                st_d.dtab[seg_app].base = seg_base;
                st_d.dtab[seg_app].len  = seg_len;
            end else begin
                st_d.itab[seg_app].base = seg_base;
                st_d.itab[seg_app].len  = seg_len;
            end
        end
        if (perm_we) st_d.perm[perm_app] = perm_row;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_app    = st_q.cur;
    assign fault      = st_q.flt;
    assign fault_kind = st_q.kind;
    assign fault_addr = st_q.faddr;
    assign fault_app  = st_q.fapp;

    // R5: nothing is granted while a fault is pending
    a_r5_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!acc_ok && !call_ok && !ret_ok));
    // R5: a fault persists until cleared
    a_r5_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !exc_clear) |=> fault);
    // R6: dispatch selects the active slot
    a_r6_dispatch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_valid |=> (cur_app == $past(dispatch_app)));
    // R7: a refused call leaves the active slot alone
    a_r7_denied_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (call_valid && !call_ok && !dispatch_valid) |=> (cur_app == $past(cur_app)));
    // R4: a fault only rises after a request
    a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(acc_valid || call_valid || ret_valid));
    // R2: a grant needs a request
    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ok |-> acc_valid);
    // R11: only one switch kind per cycle
    a_r11_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({call_ok, ret_ok, dispatch_valid && call_valid}) <= 1);
endmodule

// File: tb/segg_top_bench.sv
module segg_top_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seg_we, seg_is_data, perm_we, dispatch_valid, acc_valid;
    logic call_valid, ret_valid, exc_clear;
    logic [2:0]  seg_app, perm_app, dispatch_app, call_app;
    logic [14:0] seg_base, acc_addr;
    logic [15:0] seg_len;
    logic [7:0]  perm_row;
    logic [1:0]  acc_type, acc_size;
    logic acc_ok, call_ok, ret_ok, fault;
    logic [2:0]  cur_app, fault_kind, fault_app;
    logic [14:0] fault_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    segg_top u_segg_top (
        .clk(clk), .rst_n(rst_n),
        .seg_we(seg_we), .seg_is_data(seg_is_data), .seg_app(seg_app),
        .seg_base(seg_base), .seg_len(seg_len),
        .perm_we(perm_we), .perm_app(perm_app), .perm_row(perm_row),
        .dispatch_valid(dispatch_valid), .dispatch_app(dispatch_app),
        .acc_valid(acc_valid), .acc_type(acc_type), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_ok(acc_ok),
        .call_valid(call_valid), .call_app(call_app), .call_ok(call_ok),
        .ret_valid(ret_valid), .ret_ok(ret_ok), .exc_clear(exc_clear),
        .cur_app(cur_app), .fault(fault), .fault_kind(fault_kind),
        .fault_addr(fault_addr), .fault_app(fault_app)
    );

    int vecs = 0;
    int errs = 0;
    string scen = "R1";

    // behavioural reference state
    int m_ib[8], m_il[8], m_db[8], m_dl[8], m_perm[8];
    int a_ib, a_il, a_db, a_dl, m_cur, m_flt, m_kind, m_faddr, m_fapp;
    int stk[$];

    task automatic chk(string tag, int act, int exp, string what);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s/%s %s: actual %0d expected %0d at %0t", tag, scen, what, act, exp, $time);
        end
    endtask

    function automatic int inb(int b, int l, int a, int s);
        return (a >= b && a + (1 << s) <= b + l) ? 1 : 0;
    endfunction

    task automatic idle();
        seg_we = 0; seg_is_data = 0; seg_app = 0; seg_base = 0; seg_len = 0;
        perm_we = 0; perm_app = 0; perm_row = 0;
        dispatch_valid = 0; dispatch_app = 0;
        acc_valid = 0; acc_type = 0; acc_addr = 0; acc_size = 0;
        call_valid = 0; call_app = 0; ret_valid = 0; exc_clear = 0;
    endtask

    // compare, then advance the model, then wait for the next drive point
    task automatic cyc();
        int e_go, e_inb, e_viol, e_aok, open, e_cok, e_rok, pbit, t, nk, nf, na, nap;
        #1;
        chk("R6", int'(cur_app), m_cur, "cur_app");
        chk("R4", int'(fault), m_flt, "fault");
        if (m_flt != 0) begin
            chk("R4", int'(fault_kind), m_kind, "fault_kind");
            chk("R4", int'(fault_addr), m_faddr, "fault_addr");
            chk("R4", int'(fault_app), m_fapp, "fault_app");
        end
        e_go = (acc_valid && m_flt == 0) ? 1 : 0;
        if (acc_type == 2'b00) e_inb = inb(a_ib, a_il, int'(acc_addr), int'(acc_size));
        else                   e_inb = inb(a_db, a_dl, int'(acc_addr), int'(acc_size));
        e_viol = e_go & (1 - e_inb);
        e_aok  = e_go & e_inb;
        open   = (m_flt == 0 && e_viol == 0 && !dispatch_valid) ? 1 : 0;
        t      = int'(call_app);
        pbit   = (m_perm[m_cur] >> t) & 1;
        e_cok  = (call_valid && open != 0 && pbit != 0 && stk.size() < 4) ? 1 : 0;
        e_rok  = (ret_valid && !call_valid && open != 0 && stk.size() > 0) ? 1 : 0;
        chk("R2", int'(acc_ok), e_aok, "acc_ok");
        chk("R7", int'(call_ok), e_cok, "call_ok");
        chk("R9", int'(ret_ok), e_rok, "ret_ok");
        // next state
        nf = 0; nk = 0; na = 0; nap = m_cur;
        if (e_viol != 0) begin
            nf = 1; na = int'(acc_addr);
            nk = (acc_type == 2'b00) ? 0 : (acc_type == 2'b01) ? 1 : 2;
        end else if (call_valid && open != 0 && e_cok == 0) begin
            nf = 1; na = t; nk = (pbit == 0) ? 3 : 4;
        end else if (ret_valid && !call_valid && open != 0 && stk.size() == 0) begin
            nf = 1; na = 0; nk = 5;
        end
        if (dispatch_valid) begin
            m_cur = int'(dispatch_app);
            stk.delete();
            a_ib = m_ib[m_cur]; a_il = m_il[m_cur]; a_db = m_db[m_cur]; a_dl = m_dl[m_cur];
        end else if (e_cok != 0) begin
            stk.push_back(m_cur);
            m_cur = t;
            a_ib = m_ib[m_cur]; a_il = m_il[m_cur]; a_db = m_db[m_cur]; a_dl = m_dl[m_cur];
        end else if (e_rok != 0) begin
            m_cur = stk.pop_back();
            a_ib = m_ib[m_cur]; a_il = m_il[m_cur]; a_db = m_db[m_cur]; a_dl = m_dl[m_cur];
        end
        if (nf != 0) begin
            m_flt = 1; m_kind = nk; m_faddr = na; m_fapp = nap;
        end else if (m_flt != 0 && exc_clear) begin
            m_flt = 0;
        end
        if (seg_we) begin
            if (seg_is_data) begin m_db[seg_app] = int'(seg_base); m_dl[seg_app] = int'(seg_len); end
            else begin m_ib[seg_app] = int'(seg_base); m_il[seg_app] = int'(seg_len); end
        end
        if (perm_we) m_perm[perm_app] = int'(perm_row);
        @(negedge clk);
    endtask

    task automatic t_seg(int app, int isd, int b, int l);
        seg_we = 1; seg_is_data = isd[0]; seg_app = 3'(app); seg_base = 15'(b); seg_len = 16'(l);
        cyc(); idle();
    endtask
    task automatic t_perm(int app, int row);
        perm_we = 1; perm_app = 3'(app); perm_row = 8'(row); cyc(); idle();
    endtask
    task automatic t_disp(int app);
        dispatch_valid = 1; dispatch_app = 3'(app); cyc(); idle();
    endtask
    task automatic t_acc(int ty, int a, int s);
        acc_valid = 1; acc_type = 2'(ty); acc_addr = 15'(a); acc_size = 2'(s); cyc(); idle();
    endtask
    task automatic t_call(int app);
        call_valid = 1; call_app = 3'(app); cyc(); idle();
    endtask
    task automatic t_ret();
        ret_valid = 1; cyc(); idle();
    endtask
    task automatic t_clr();
        exc_clear = 1; cyc(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; vecs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        for (int i = 0; i < 8; i++) begin
            m_ib[i] = 0; m_il[i] = 0; m_db[i] = 0; m_dl[i] = 0; m_perm[i] = 0;
        end
        a_ib = 0; a_il = 0; a_db = 0; a_dl = 0;
        m_cur = 0; m_flt = 0; m_kind = 0; m_faddr = 0; m_fapp = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state, everything refused
        scen = "R1";
        cyc();
        t_acc(0, 0, 0);
        t_clr();
        t_call(1);
        t_clr();

        // table setup
        scen = "R10";
        for (int i = 0; i < 8; i++) begin
            t_seg(i, 0, i * 'h400, 'h400 - i * 'h40);
            t_seg(i, 1, 'h4000 + i * 'h200, (i == 5) ? 0 : 'h180);
        end
        t_perm(0, 'b0000_0110);
        t_perm(1, 'b0000_0001);

        // R2: window edges
        scen = "R2";
        t_disp(0);
        t_acc(0, 'h3FC, 2);
        t_acc(0, 'h3FE, 2);
        t_clr();
        t_acc(1, 'h417F, 0);
        t_acc(2, 'h4178, 3);
        t_acc(2, 'h4180, 0);
        t_clr();
        t_acc(1, 'h3FFF, 0);
        t_clr();
        t_acc(1, 'h0000, 0);
        t_clr();

        // R3: empty data window
        scen = "R3";
        t_disp(5);
        t_acc(1, 'h4A00, 0);
        t_clr();
        t_acc(0, 'h1400, 0);

        // R7 and R9: permitted and refused calls
        scen = "R7";
        t_disp(0);
        t_call(3);
        t_clr();
        t_call(1);
        t_acc(0, 'h400, 1);
        t_acc(0, 'h3FF, 0);
        t_clr();
        scen = "R9";
        t_ret();
        t_acc(0, 'h3FF, 0);
        t_ret();
        t_clr();

        // R8: stack depth
        scen = "R8";
        for (int i = 0; i < 8; i++) t_perm(i, 'hFF);
        t_disp(0);
        t_call(1); t_call(2); t_call(3); t_call(4);
        t_call(5);
        t_clr();
        for (int i = 0; i < 4; i++) t_ret();
        t_ret();
        t_clr();

        // R6: dispatch flushes the stack; table write does not touch active window
        scen = "R6";
        t_call(2);
        t_disp(3);
        t_ret();
        t_clr();
        t_seg(3, 0, 'h0, 'h10);
        t_acc(0, 'hC00, 2);
        t_disp(3);
        t_acc(0, 'hC00, 2);
        t_clr();
        t_seg(3, 0, 'hC00, 'h340);

        // R5: suppression while a fault is pending
        scen = "R5";
        t_disp(1);
        t_acc(1, 'h0, 0);
        t_acc(1, 'h4200, 0);
        t_call(2);
        t_ret();
        t_acc(0, 'h400, 0);
        t_clr();
        t_acc(1, 'h4200, 0);

        // R11: same-cycle priorities
        scen = "R11";
        dispatch_valid = 1; dispatch_app = 2; call_valid = 1; call_app = 4; cyc(); idle();
        call_valid = 1; call_app = 6; ret_valid = 1; cyc(); idle();
        acc_valid = 1; acc_type = 1; acc_addr = 'h0; call_valid = 1; call_app = 1; cyc(); idle();
        t_clr();
        acc_valid = 1; acc_type = 0; acc_addr = 'h1800; call_valid = 1; call_app = 1; cyc(); idle();
        acc_valid = 1; acc_type = 0; acc_addr = 'h1800; ret_valid = 1; cyc(); idle();
        acc_valid = 1; acc_type = 0; acc_addr = 'h0; ret_valid = 1; cyc(); idle();
        t_clr();

        // mixed traffic
        scen = "R2";
        lf = 32'h1234_5678;
        for (int n = 0; n < 1500; n++) begin
            int op, ap, base;
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            op = int'(lf[3:0]);
            ap = int'(lf[6:4]);
            if (n % 61 == 7) t_perm(ap, int'(lf[15:8]));
            acc_valid = (op < 9);
            acc_type = lf[17:16];
            base = (acc_type == 2'b00) ? ap * 'h400 : 'h4000 + ap * 'h200;
            acc_addr = 15'(base + int'(lf[27:18]) - 'h40);
            acc_size = lf[29:28];
            call_valid = (op == 9 || op == 10);
            call_app = lf[21:19];
            ret_valid = (op >= 11 && op <= 12);
            dispatch_valid = (op == 13 && lf[30]);
            dispatch_app = 3'(ap);
            exc_clear = (op == 14 || op == 15);
            cyc(); idle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule